// File: doc/BRIEF.md
# Segment Pair Extrapolation Matcher

This block judges whether two track segments, taken at two different detector stations, are compatible with one particle track. Each segment gives a polar coordinate (eta), an azimuthal coordinate (phi), a bend angle and a two-bit quality. The block forms the signed eta and phi differences between the pair. It tests the eta difference against a window and the phi difference against limits derived from each segment's bend angle. It also grades the phi difference against three thresholds. A match is declared only when the eta test and both bend-limit tests pass. A quality code for the pair is then read from a table.

All windows, thresholds, limits and the quality mapping live in small lookup RAMs. A host loads them through a table-select/address/data/write-enable port while no pair is in flight. Pairs may be offered every cycle. Each result appears a fixed two cycles later with a valid strobe.

Top module: `segPairMatcher`

## Requirements
- R1: A pair presented with `inValid` high before clock edge N gives its result with `outValid` high after edge N+1. `outValid` is high in no other cycle, and a new pair may be offered on every cycle.
- R2: With dEta = etaA - etaB (signed), the eta test passes when |dEta| <= the eta-window table entry addressed by etaA.
- R3: With dPhi = phiA - phiB (signed), the A-side bend test passes when lowA[phibA] <= dPhi <= highA[phibA], both limits being signed table entries.
- R4: The B-side bend test passes when lowB[phibB] <= dPhi <= highB[phibB].
- R5: `outMatch` is high exactly when the eta test, the A-side bend test and the B-side bend test all pass.
- R6: Three graded tests compare |dPhi| <= threshold for the high, medium and low tables, each addressed by etaA. A matched pair takes its quality from the quality table at index {high, medium, low, qualA, qualB}, with the high result in bit 6 and qualB in bits 1:0.
- R7: When `outValid` is high and `outMatch` is low, `outQual` is zero.
- R8: A host write with `tblWe` high stores `tblWData` (low bits as wide as the table) at `tblAddr` in the table chosen by `tblSel`. The codes are: 0 eta window, 1 high threshold, 2 medium threshold, 3 low threshold, 4 lowA, 5 highA, 6 lowB, 7 highB, 8 quality. Codes 9 to 15 change no table.
- R9: While `rst` is high and in the cycle after it, `outValid`, `outMatch` and `outQual` are zero.
- R10: Whenever `outValid` is low, `outMatch` and `outQual` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | A segment pair is presented this cycle |
| etaA | input | 4 | Eta of segment A (unsigned) |
| etaB | input | 4 | Eta of segment B (unsigned) |
| phiA | input | 5 | Phi of segment A (unsigned) |
| phiB | input | 5 | Phi of segment B (unsigned) |
| phibA | input | 3 | Bend angle code of segment A |
| phibB | input | 3 | Bend angle code of segment B |
| qualA | input | 2 | Quality of segment A |
| qualB | input | 2 | Quality of segment B |
| tblWe | input | 1 | Host table write enable |
| tblSel | input | 4 | Host table select code |
| tblAddr | input | 7 | Host table write address |
| tblWData | input | 6 | Host table write data |
| outValid | output | 1 | Result strobe |
| outMatch | output | 1 | Pair accepted |
| outQual | output | 2 | Extrapolation quality |

## Verification
In every cycle of a stream, the stage-one capture of a new pair overlaps the resolution and output of the pair offered one cycle earlier. Long back-to-back sweeps with periodic bubbles are used to provoke this. The bench keeps a two-deep queue of expectations and compares each output cycle against the entry pushed two cycles before. Bubbles must yield quiet outputs, with no stale match or quality carried over from the previous pair.

// File: rtl/segMatchPkg.sv
package segMatchPkg;
  localparam int SEL_W   = 4;
  localparam int NUM_TBL = 9;

  localparam int TBL_ETA_WIN = 0;
  localparam int TBL_THR_HI  = 1;  // medium = 2, low = 3
  localparam int TBL_BEND_LA = 4;  // highA = 5, lowB = 6, highB = 7
  localparam int TBL_QUAL    = 8;

  typedef struct packed {
    logic capture;  // load stage-one pair registers
    logic resolve;  // stage-one content is a live pair, register its result
  } ctrlStrobes_t;
endpackage

// File: rtl/lutRam.sv
module lutRam #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 6,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    wAddr,
  input  logic [WIDTH-1:0] wData,
  input  logic [AW-1:0]    rAddr,
  output logic [WIDTH-1:0] rData
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wAddr] <= wData;
  end

  assign rData = mem[rAddr];
endmodule

// File: rtl/segMatchCtrl.sv
module segMatchCtrl
  import segMatchPkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  output ctrlStrobes_t strb,
  output logic         outValid
);
  logic stageOneLive;

  always_ff @(posedge clk) begin
    if (rst) begin
      stageOneLive <= 1'b0;
      outValid     <= 1'b0;
    end else begin
      stageOneLive <= inValid;
      outValid     <= stageOneLive;
    end
  end

  always_comb begin
    strb.capture = inValid;
    strb.resolve = stageOneLive;
  end
endmodule

// File: rtl/segMatchDatapath.sv
module segMatchDatapath
  import segMatchPkg::*;
#(
  parameter int ETA_W  = 4,
  parameter int PHI_W  = 5,
  parameter int PHIB_W = 3,
  parameter int QUAL_W = 2,
  parameter int QOUT_W = 2,
  parameter int ADDR_W = 7,
  parameter int DATA_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobes_t      strb,
  input  logic [ETA_W-1:0]  etaA,
  input  logic [ETA_W-1:0]  etaB,
  input  logic [PHI_W-1:0]  phiA,
  input  logic [PHI_W-1:0]  phiB,
  input  logic [PHIB_W-1:0] phibA,
  input  logic [PHIB_W-1:0] phibB,
  input  logic [QUAL_W-1:0] qualA,
  input  logic [QUAL_W-1:0] qualB,
  input  logic              tblWe,
  input  logic [SEL_W-1:0]  tblSel,
  input  logic [ADDR_W-1:0] tblAddr,
  input  logic [DATA_W-1:0] tblWData,
  output logic              outMatch,
  output logic [QOUT_W-1:0] outQual
);
  localparam int QIDX_W = 3 + 2 * QUAL_W;

  // stage one: captured pair
  logic [ETA_W-1:0]  sEtaA, sEtaB;
  logic [PHI_W-1:0]  sPhiA, sPhiB;
  logic [PHIB_W-1:0] sPhibA, sPhibB;
  logic [QUAL_W-1:0] sQualA, sQualB;

  always_ff @(posedge clk) begin
    if (rst) begin
      sEtaA <= '0; sEtaB <= '0; sPhiA <= '0; sPhiB <= '0;
      sPhibA <= '0; sPhibB <= '0; sQualA <= '0; sQualB <= '0;
    end else if (strb.capture) begin
      sEtaA <= etaA; sEtaB <= etaB; sPhiA <= phiA; sPhiB <= phiB;
      sPhibA <= phibA; sPhibB <= phibB; sQualA <= qualA; sQualB <= qualB;
    end
  end

  // host write decode
  logic [NUM_TBL-1:0] weVec;
  always_comb begin
    for (int k = 0; k < NUM_TBL; k++)
      weVec[k] = tblWe && (tblSel == SEL_W'(k));
  end

  // eta window table
  logic [ETA_W-1:0] etaWinRd;
  lutRam #(.DEPTH(1 << ETA_W), .WIDTH(ETA_W)) uEtaWin (
    .clk(clk), .we(weVec[TBL_ETA_WIN]), .wAddr(tblAddr[ETA_W-1:0]),
    .wData(tblWData[ETA_W-1:0]), .rAddr(sEtaA), .rData(etaWinRd));

  // graded phi thresholds: 0 high, 1 medium, 2 low
  logic [PHI_W-1:0] thrRd [3];
  for (genvar g = 0; g < 3; g++) begin : gThr
    lutRam #(.DEPTH(1 << ETA_W), .WIDTH(PHI_W)) uThr (
      .clk(clk), .we(weVec[TBL_THR_HI + g]), .wAddr(tblAddr[ETA_W-1:0]),
      .wData(tblWData[PHI_W-1:0]), .rAddr(sEtaA), .rData(thrRd[g]));
  end

  // bend limits: 0 lowA, 1 highA, 2 lowB, 3 highB
  logic [DATA_W-1:0] bendRd [4];
  for (genvar g = 0; g < 4; g++) begin : gBend
    logic [PHIB_W-1:0] bendAddr;
    assign bendAddr = (g < 2) ? sPhibA : sPhibB;
    lutRam #(.DEPTH(1 << PHIB_W), .WIDTH(DATA_W)) uBend (
      .clk(clk), .we(weVec[TBL_BEND_LA + g]), .wAddr(tblAddr[PHIB_W-1:0]),
      .wData(tblWData), .rAddr(bendAddr), .rData(bendRd[g]));
  end

  // quality table
  logic [QIDX_W-1:0] qIdx;
  logic [QOUT_W-1:0] qRd;
  lutRam #(.DEPTH(1 << QIDX_W), .WIDTH(QOUT_W)) uQual (
    .clk(clk), .we(weVec[TBL_QUAL]), .wAddr(tblAddr[QIDX_W-1:0]),
    .wData(tblWData[QOUT_W-1:0]), .rAddr(qIdx), .rData(qRd));

  // road arithmetic
  logic signed [ETA_W:0] dEta;
  logic        [ETA_W:0] absEta;
  logic signed [PHI_W:0] dPhi;
  logic        [PHI_W:0] absPhi;
  logic                  etaPass, bendOkA, bendOkB, matchNow;
  logic [2:0]            gradePass;

  always_comb begin
    dEta    = $signed({1'b0, sEtaA}) - $signed({1'b0, sEtaB});
    absEta  = dEta[ETA_W] ? -dEta : dEta;
    etaPass = absEta <= {1'b0, etaWinRd};

    dPhi   = $signed({1'b0, sPhiA}) - $signed({1'b0, sPhiB});
    absPhi = dPhi[PHI_W] ? -dPhi : dPhi;
    for (int g = 0; g < 3; g++)
      gradePass[g] = absPhi <= {1'b0, thrRd[g]};

    bendOkA = ($signed(bendRd[0]) <= dPhi) && (dPhi <= $signed(bendRd[1]));
    bendOkB = ($signed(bendRd[2]) <= dPhi) && (dPhi <= $signed(bendRd[3]));

    matchNow = etaPass && bendOkA && bendOkB;
    qIdx     = {gradePass[0], gradePass[1], gradePass[2], sQualA, sQualB};
  end

  // stage two: result registers
  always_ff @(posedge clk) begin
    if (rst || !strb.resolve) begin
      outMatch <= 1'b0;
      outQual  <= '0;
    end else begin
      outMatch <= matchNow;
      outQual  <= matchNow ? qRd : '0;
    end
  end
endmodule

// File: rtl/segPairMatcher.sv
module segPairMatcher
  import segMatchPkg::*;
#(
  parameter int ETA_W  = 4,
  parameter int PHI_W  = 5,
  parameter int PHIB_W = 3,
  parameter int QUAL_W = 2,
  parameter int QOUT_W = 2,
  localparam int DATA_W = PHI_W + 1,
  localparam int QIDX_W = 3 + 2 * QUAL_W,
  localparam int ADDR_W = (QIDX_W > ETA_W) ? ((QIDX_W > PHIB_W) ? QIDX_W : PHIB_W)
                                           : ((ETA_W > PHIB_W) ? ETA_W : PHIB_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [ETA_W-1:0]  etaA,
  input  logic [ETA_W-1:0]  etaB,
  input  logic [PHI_W-1:0]  phiA,
  input  logic [PHI_W-1:0]  phiB,
  input  logic [PHIB_W-1:0] phibA,
  input  logic [PHIB_W-1:0] phibB,
  input  logic [QUAL_W-1:0] qualA,
  input  logic [QUAL_W-1:0] qualB,
  input  logic              tblWe,
  input  logic [SEL_W-1:0]  tblSel,
  input  logic [ADDR_W-1:0] tblAddr,
  input  logic [DATA_W-1:0] tblWData,
  output logic              outValid,
  output logic              outMatch,
  output logic [QOUT_W-1:0] outQual
);
  ctrlStrobes_t strb;

  segMatchCtrl uCtrl (
    .clk(clk), .rst(rst), .inValid(inValid), .strb(strb), .outValid(outValid));

  segMatchDatapath #(
    .ETA_W(ETA_W), .PHI_W(PHI_W), .PHIB_W(PHIB_W), .QUAL_W(QUAL_W),
    .QOUT_W(QOUT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) uDp (
    .clk(clk), .rst(rst), .strb(strb),
    .etaA(etaA), .etaB(etaB), .phiA(phiA), .phiB(phiB),
    .phibA(phibA), .phibB(phibB), .qualA(qualA), .qualB(qualB),
    .tblWe(tblWe), .tblSel(tblSel), .tblAddr(tblAddr), .tblWData(tblWData),
    .outMatch(outMatch), .outQual(outQual));
endmodule

// File: rtl/segPairMatcherChk.sv
module segPairMatcherChk #(
  parameter int QOUT_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic              outValid,
  input logic              outMatch,
  input logic [QOUT_W-1:0] outQual
);
  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (rst)
    outValid == $past(inValid, 2)); // R1

  AST_CLEAR_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!outValid && !outMatch && outQual == '0)); // R9

  AST_NO_MATCH_NO_QUAL: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outMatch) |-> outQual == '0); // R7

  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> (!outMatch && outQual == '0)); // R10
endmodule

bind segPairMatcher segPairMatcherChk #(.QOUT_W(QOUT_W)) uChk (
  .clk(clk), .rst(rst), .inValid(inValid), .outValid(outValid),
  .outMatch(outMatch), .outQual(outQual));

// File: tb/sim_segPairMatcher.sv
module sim_segPairMatcher;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       inValid = 1'b0;
  logic [3:0] etaA = '0, etaB = '0;
  logic [4:0] phiA = '0, phiB = '0;
  logic [2:0] phibA = '0, phibB = '0;
  logic [1:0] qualA = '0, qualB = '0;
  logic       tblWe = 1'b0;
  logic [3:0] tblSel = '0;
  logic [6:0] tblAddr = '0;
  logic [5:0] tblWData = '0;
  logic       outValid, outMatch;
  logic [1:0] outQual;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // bench copies of table contents
  int etaWinT [16];
  int thrT [3][16];
  int loAT [8], hiAT [8], loBT [8], hiBT [8];
  int qualT [128];

  // two-deep expectation queue
  bit expV1 = 0, expV2 = 0, expM1 = 0, expM2 = 0;
  int expQ1 = 0, expQ2 = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  segPairMatcher u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .etaA(etaA), .etaB(etaB),
    .phiA(phiA), .phiB(phiB), .phibA(phibA), .phibB(phibB),
    .qualA(qualA), .qualB(qualB), .tblWe(tblWe), .tblSel(tblSel),
    .tblAddr(tblAddr), .tblWData(tblWData),
    .outValid(outValid), .outMatch(outMatch), .outQual(outQual));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input int sel, input int addr, input int data);
    @(negedge clk);
    tblWe = 1'b1; tblSel = 4'(sel); tblAddr = 7'(addr); tblWData = 6'(data);
    @(negedge clk);
    tblWe = 1'b0;
  endtask

  function automatic int absI(input int x);
    return (x < 0) ? -x : x;
  endfunction

  function automatic void model(input int ea, eb, pa, pb, ba, bb, qa, qb,
                                output bit m, output int q);
    int dEta, dPhi, idx;
    bit etaOk, okA, okB, h, md, l;
    dEta  = ea - eb;
    etaOk = absI(dEta) <= etaWinT[ea];                  // R2
    dPhi  = pa - pb;
    okA   = (loAT[ba] <= dPhi) && (dPhi <= hiAT[ba]);   // R3
    okB   = (loBT[bb] <= dPhi) && (dPhi <= hiBT[bb]);   // R4
    m     = etaOk && okA && okB;                        // R5
    h     = absI(dPhi) <= thrT[0][ea];                  // R6
    md    = absI(dPhi) <= thrT[1][ea];
    l     = absI(dPhi) <= thrT[2][ea];
    idx   = h * 64 + md * 32 + l * 16 + qa * 4 + qb;
    q     = m ? qualT[idx] : 0;                         // R7
  endfunction

  // one cycle: judge the result due now, then offer the next pair
  task automatic step(input bit v, input int ea, eb, pa, pb, ba, bb, qa, qb);
    bit m; int q;
    @(negedge clk);
    check(outValid == expV2, "R1", int'(outValid), int'(expV2));
    if (expV2) begin
      check(outMatch == expM2, "R5", int'(outMatch), int'(expM2));
      check(int'(outQual) == expQ2, expM2 ? "R6" : "R7", int'(outQual), expQ2);
    end else begin
      check(!outMatch && outQual == 0, "R10", int'(outMatch) * 4 + int'(outQual), 0);
    end
    model(ea, eb, pa, pb, ba, bb, qa, qb, m, q);
    expV2 = expV1; expM2 = expM1; expQ2 = expQ1;
    expV1 = v; expM1 = v && m; expQ1 = v ? q : 0;
    inValid = v;
    etaA = 4'(ea); etaB = 4'(eb); phiA = 5'(pa); phiB = 5'(pb);
    phibA = 3'(ba); phibB = 3'(bb); qualA = 2'(qa); qualB = 2'(qb);
  endtask

  task automatic drain();
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic etaSweep(input int rowLo, input int rowHi);
    int n = 0;
    for (int ea = rowLo; ea <= rowHi; ea++)
      for (int eb = 0; eb < 16; eb++) begin
        step((n % 5) != 4, ea, eb, 10, 10, 0, 0, ea % 4, eb % 4);
        n++;
      end
    drain();
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: outputs cleared while reset is held
    check(!outValid && !outMatch && outQual == 0, "R9",
          int'(outValid) * 8 + int'(outMatch) * 4 + int'(outQual), 0);
    rst = 1'b0;

    // R8: load every table while idle
    for (int e = 0; e < 16; e++) begin
      etaWinT[e] = (e * 5 + 2) % 8;
      thrT[0][e] = e % 4;
      thrT[1][e] = 4 + e % 8;
      thrT[2][e] = 12 + e % 16;
      wr(0, e, etaWinT[e]);
      for (int g = 0; g < 3; g++) wr(1 + g, e, thrT[g][e]);
    end
    for (int p = 0; p < 8; p++) begin
      loAT[p] = -4 * p - 2; hiAT[p] = 3 * p + 1;
      loBT[p] = -3 * p - 1; hiBT[p] = 4 * p + 2;
      wr(4, p, loAT[p]); wr(5, p, hiAT[p]); wr(6, p, loBT[p]); wr(7, p, hiBT[p]);
    end
    for (int i = 0; i < 128; i++) begin
      qualT[i] = (i * 5 + i / 8) % 4;
      wr(8, i, qualT[i]);
    end

    @(negedge clk);
    check(!outValid, "R9", int'(outValid), 0);

    // R2: eta differences across every pair of eta codes, with bubbles
    etaSweep(0, 15);

    // R3 R4 R6: phi differences and bend codes, streamed back to back
    for (int pa = 0; pa < 32; pa++)
      for (int pb = 0; pb < 32; pb++)
        step(1, pa % 16, pa % 16, pa, pb, pa % 8, (pb * 3) % 8, (pa + pb) % 4, pb / 8);
    drain();

    // R8: codes 9..15 must leave every table untouched
    for (int s = 9; s < 16; s++)
      for (int a = 0; a < 128; a += 5) wr(s, a, 6'h2a ^ a);
    etaSweep(0, 3);
    for (int pa = 0; pa < 32; pa += 3)
      for (int pb = 0; pb < 32; pb += 2)
        step(1, pa % 16, (pa + 1) % 16, pa, pb, pb % 8, pa % 8, pa % 4, pb % 4);
    drain();

    // R8: rewrite a live entry and observe its effect
    etaWinT[3] = 15;
    wr(0, 3, 15);
    etaSweep(3, 3);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule